// File: doc/BRIEF.md
# Module Clock/Reset State Controller

This block drives the clock-enable and active-low reset lines of a bank of local modules that share one always-on power domain. Each module has a control word that holds a requested next state and a status word that reports the state the module is in now. Software fills in the requested states first. It then writes a start command for the domain. From that point the controller walks every module whose requested state differs from its current state through a fixed handshake. While the batch runs, one shared busy flag is set.

Each module can be in one of three states, encoded in two bits. Off (0) means clock gated and reset held. Synchronous reset (1) means clock running and reset held. On (3) means clock running and reset released. Every transition follows the same four-step sequence. The clock is ungated before reset is released. Reset is asserted before the clock is gated. The status word only changes on the last step. A simple 32-bit register port gives access to the command, the busy flag, the per-module control words and the per-module status words.

Top module: `modstate_ctrl`

## Requirements
- R1: After synchronous reset, every module reads state 0 with its clock enable low and its reset output low. Every control word reads 0, and the busy flag (bit 0 at offset 0x004) reads 0.
- R2: The control word of module i is at 0x200 + 4*i, with the requested state in bits [1:0], and it reads back as written. A write whose bits [1:0] equal the unused code 2 leaves the requested state as it was.
- R3: Bit 9 of a control word is a read/write flag that keeps its value until it is rewritten. Every other bit of the control word, apart from [1:0], reads 0. The flag has no effect on any module output.
- R4: Writing a control word without a start command changes neither the module outputs nor the status word (0x100 + 4*i, state in bits [1:0]).
- R5: Writing 1 to bit 0 at offset 0x000 while idle sets busy for exactly four cycles. The status words of the affected modules take their new state on the edge where busy clears.
- R6: In a batch, the clock enable rises on the first edge after the start, the reset output changes on the second, and the clock enable falls on the third. A reset release therefore always follows a running clock by at least one cycle, and a clock gate always follows an asserted reset by at least one cycle.
- R7: A module whose requested state equals its current state when the start is accepted keeps its outputs and status unchanged for the whole batch.
- R8: A start command written while busy is ignored. A control word written while busy does not change the batch in progress.
- R9: Accesses to module indices at or above the configured count are ignored: writes have no effect and reads return 0.
- R10: A write to offset 0x000 with bit 0 clear starts nothing.
- R11: When idle, each module's outputs match its status: state 0 gives clock off and reset low, state 1 gives clock on and reset low, and state 3 gives clock on and reset high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears one cycle later |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_rst_n | output | NUM_MOD | Per-module reset, active low |

## Verification
A wrong phase counter or a wrong snapshot of the requested states shows up on the clock-enable and reset pins within one to four cycles of the start command. Typical symptoms are a reset released in the same cycle as the clock, or a module that should have stayed put moving anyway. A stale status word or a busy flag that is too long or too short only becomes visible when software reads it. For that reason the bench polls the busy and status words on many cycles inside and around each batch, and it compares both pins on every cycle against a behavioural model.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  // module state codes (two bits)
  localparam logic [1:0] ST_OFF  = 2'd0;
  localparam logic [1:0] ST_SRST = 2'd1;
  localparam logic [1:0] ST_BAD  = 2'd2;
  localparam logic [1:0] ST_ON   = 2'd3;

  // address bits covered by one per-module slot region
  localparam int SLOT_BITS = 8;
  localparam int FLAG_BIT  = 9;

  typedef enum logic [1:0] {
    PH_CLKON  = 2'd0,
    PH_RESET  = 2'd1,
    PH_CLKOFF = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;

  function automatic logic clk_wanted(input logic [1:0] s);
    return s != ST_OFF;
  endfunction

  function automatic logic release_wanted(input logic [1:0] s);
    return s == ST_ON;
  endfunction
endpackage

// File: rtl/mcs_regfile.sv
module mcs_regfile
  import mcs_pkg::*;
#(
  parameter int NUM_MOD = 8,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h000,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h004,
  parameter logic [ADDR_W-1:0] STS_BASE = 'h100,
  parameter logic [ADDR_W-1:0] CTL_BASE = 'h200
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    busy,
  input  logic [NUM_MOD-1:0][1:0] cur_state,
  output logic [NUM_MOD-1:0][1:0] req_state,
  output logic                    go_req
);
  localparam int IDX_W = SLOT_BITS - 2;

  logic [IDX_W-1:0]   idx;
  logic               ctl_hit, sts_hit, idx_ok, ctl_wr;
  logic [NUM_MOD-1:0] flag_q;
  logic [31:0]        rd_mux;
  logic               unused_wbits;

  assign idx     = bus_addr[SLOT_BITS-1:2];
  assign ctl_hit = (bus_addr[ADDR_W-1:SLOT_BITS] == CTL_BASE[ADDR_W-1:SLOT_BITS])
                   && (bus_addr[1:0] == 2'b00);
  assign sts_hit = (bus_addr[ADDR_W-1:SLOT_BITS] == STS_BASE[ADDR_W-1:SLOT_BITS])
                   && (bus_addr[1:0] == 2'b00);
  assign idx_ok  = int'(idx) < NUM_MOD;
  assign ctl_wr  = bus_wr && ctl_hit && idx_ok;
  assign go_req  = bus_wr && (bus_addr == CMD_OFS) && bus_wdata[0];
  assign unused_wbits = ^{bus_wdata[31:FLAG_BIT+1], bus_wdata[FLAG_BIT-1:2]};

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_slot
    logic hit;
    assign hit = (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        req_state[g] <= ST_OFF;
        flag_q[g]    <= 1'b0;
      end else if (ctl_wr && hit) begin
        flag_q[g] <= bus_wdata[FLAG_BIT];
        if (bus_wdata[1:0] != ST_BAD)
          req_state[g] <= bus_wdata[1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == STAT_OFS) begin
      rd_mux = {31'b0, busy};
    end else if (ctl_hit) begin
      for (int i = 0; i < NUM_MOD; i++)
        if (idx == IDX_W'(i))
          rd_mux = {22'b0, flag_q[i], 7'b0, req_state[i]};
    end else if (sts_hit) begin
      for (int i = 0; i < NUM_MOD; i++)
        if (idx == IDX_W'(i))
          rd_mux = {30'b0, cur_state[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= rd_mux;
  end

  // R9: an out-of-range slot write leaves every control word alone
  assert_oob_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctl_hit && !idx_ok) |=> ($stable(req_state) && $stable(flag_q)));

  // R2: the unused code never lands in a requested-state field
  assert_bad_code_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctl_hit && bus_wdata[1:0] == ST_BAD) |=> $stable(req_state));
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int NUM_MOD = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go_req,
  input  logic [NUM_MOD-1:0][1:0] req_state,
  input  logic [NUM_MOD-1:0][1:0] cur_state,
  output logic                    busy,
  output logic [NUM_MOD-1:0]      pend,
  output logic [NUM_MOD-1:0][1:0] tgt,
  output logic                    do_clkon,
  output logic                    do_reset,
  output logic                    do_clkoff,
  output logic                    do_commit
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      phase_q <= PH_CLKON;
      pend    <= '0;
      tgt     <= '0;
    end else if (!busy) begin
      if (go_req) begin
        busy    <= 1'b1;
        phase_q <= PH_CLKON;
        tgt     <= req_state;
        for (int i = 0; i < NUM_MOD; i++)
          pend[i] <= (req_state[i] != cur_state[i]);
      end
    end else begin
      case (phase_q)
        PH_CLKON:  phase_q <= PH_RESET;
        PH_RESET:  phase_q <= PH_CLKOFF;
        PH_CLKOFF: phase_q <= PH_COMMIT;
        default: begin
          phase_q <= PH_CLKON;
          busy    <= 1'b0;
        end
      endcase
    end
  end

  assign do_clkon  = busy && (phase_q == PH_CLKON);
  assign do_reset  = busy && (phase_q == PH_RESET);
  assign do_clkoff = busy && (phase_q == PH_CLKOFF);
  assign do_commit = busy && (phase_q == PH_COMMIT);

  // R5: busy never lasts a single cycle and only drops after the commit step
  assert_busy_min_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(phase_q) == PH_COMMIT);

  // R8: the batch targets are frozen while busy
  assert_frozen_batch_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tgt) && $stable(pend)));
endmodule

// File: rtl/mcs_lane.sv
module mcs_lane
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic [1:0] tgt,
  input  logic       do_clkon,
  input  logic       do_reset,
  input  logic       do_clkoff,
  input  logic       do_commit,
  output logic       clk_en,
  output logic       rst_n,
  output logic [1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en <= 1'b0;
      rst_n  <= 1'b0;
      cur    <= ST_OFF;
    end else if (sel) begin
      if (do_clkon && clk_wanted(tgt))   clk_en <= 1'b1;
      if (do_reset)                      rst_n  <= release_wanted(tgt);
      if (do_clkoff && !clk_wanted(tgt)) clk_en <= 1'b0;
      if (do_commit)                     cur    <= tgt;
    end
  end

  // R6: reset is released only while the clock was already running
  assert_clk_before_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n) |-> $past(clk_en));
  // R6: the clock is gated only after reset has been held for a cycle
  assert_reset_before_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> (!rst_n && !$past(rst_n)));
  // R7: an unselected lane does not move during a batch
  assert_untouched_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel && (do_clkon || do_reset || do_clkoff || do_commit))
      |=> ($stable(clk_en) && $stable(rst_n) && $stable(cur)));
endmodule

// File: rtl/modstate_ctrl.sv
module modstate_ctrl
  import mcs_pkg::*;
#(
  parameter int NUM_MOD = 8,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h000,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h004,
  parameter logic [ADDR_W-1:0] STS_BASE = 'h100,
  parameter logic [ADDR_W-1:0] CTL_BASE = 'h200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst_n
);
  logic                    busy, go_req;
  logic                    do_clkon, do_reset, do_clkoff, do_commit;
  logic [NUM_MOD-1:0]      pend;
  logic [NUM_MOD-1:0][1:0] req_state, cur_state, tgt;

  mcs_regfile #(
    .NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS),
    .STAT_OFS(STAT_OFS), .STS_BASE(STS_BASE), .CTL_BASE(CTL_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .cur_state(cur_state), .req_state(req_state), .go_req(go_req)
  );

  mcs_sequencer #(.NUM_MOD(NUM_MOD)) u_seq (
    .clk(clk), .rst(rst), .go_req(go_req), .req_state(req_state),
    .cur_state(cur_state), .busy(busy), .pend(pend), .tgt(tgt),
    .do_clkon(do_clkon), .do_reset(do_reset), .do_clkoff(do_clkoff),
    .do_commit(do_commit)
  );

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_lane
    mcs_lane u_lane (
      .clk(clk), .rst(rst), .sel(pend[g]), .tgt(tgt[g]),
      .do_clkon(do_clkon), .do_reset(do_reset), .do_clkoff(do_clkoff),
      .do_commit(do_commit), .clk_en(mod_clk_en[g]), .rst_n(mod_rst_n[g]),
      .cur(cur_state[g])
    );

    // R11: while idle the pins agree with the reported state
    assert_idle_pins_R11: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (mod_clk_en[g] == clk_wanted(cur_state[g]))
                && (mod_rst_n[g] == release_wanted(cur_state[g])));
  end

  // R10: a command write without bit 0 leaves the domain idle
  assert_no_start_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == CMD_OFS && !bus_wdata[0] && !busy) |=> !busy);
endmodule

// File: tb/modstate_ctrl_tb.sv
module modstate_ctrl_tb;
  localparam int N = 8;
  localparam logic [11:0] A_CMD = 12'h000, A_STAT = 12'h004;
  localparam logic [11:0] A_STS = 12'h100, A_CTL = 12'h200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] mod_clk_en, mod_rst_n;

  always #2.5 clk = ~clk;

  modstate_ctrl #(.NUM_MOD(N)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );

  // behavioural reference
  int   m_cur[N], m_nxt[N], m_tgt[N];
  bit   m_flag[N], m_pend[N], m_clk[N], m_rstn[N];
  bit   m_busy;
  int   m_step;
  logic [31:0] m_rdata;
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int k;
    if (a == A_STAT) return {31'b0, m_busy};
    if (a[1:0] != 2'b00) return 0;
    if (a >= A_STS && a < A_STS + 12'h100) begin
      k = int'(a - A_STS) / 4;
      if (k < N) return 32'(m_cur[k]);
    end
    if (a >= A_CTL && a < A_CTL + 12'h100) begin
      k = int'(a - A_CTL) / 4;
      if (k < N) return (32'(m_flag[k]) << 9) | 32'(m_nxt[k]);
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_cur[i] = 0; m_nxt[i] = 0; m_tgt[i] = 0;
        m_flag[i] = 0; m_pend[i] = 0; m_clk[i] = 0; m_rstn[i] = 0;
      end
      m_busy = 0; m_step = 0; m_rdata = 0;
    end else begin
      if (bus_rd) m_rdata = model_read(bus_addr);
      if (m_busy) begin
        m_step++;
        for (int i = 0; i < N; i++) if (m_pend[i]) begin
          if (m_step == 1 && m_tgt[i] != 0) m_clk[i] = 1;
          if (m_step == 2) m_rstn[i] = (m_tgt[i] == 3);
          if (m_step == 3 && m_tgt[i] == 0) m_clk[i] = 0;
          if (m_step == 4) m_cur[i] = m_tgt[i];
        end
        if (m_step == 4) m_busy = 0;
      end else if (bus_wr && bus_addr == A_CMD && bus_wdata[0]) begin
        m_busy = 1; m_step = 0;
        for (int i = 0; i < N; i++) begin
          m_tgt[i] = m_nxt[i];
          m_pend[i] = (m_nxt[i] != m_cur[i]);
        end
      end
      if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr >= A_CTL
          && bus_addr < A_CTL + 12'h100) begin
        int k;
        k = int'(bus_addr - A_CTL) / 4;
        if (k < N) begin
          m_flag[k] = bus_wdata[9];
          if (bus_wdata[1:0] != 2'd2) m_nxt[k] = int'(bus_wdata[1:0]);
        end
      end
    end
  end

  // per-cycle pin comparison (R1 R4 R6 R7 R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [N-1:0] ec, er;
      for (int i = 0; i < N; i++) begin ec[i] = m_clk[i]; er[i] = m_rstn[i]; end
      n_vec++;
      if (mod_clk_en !== ec || mod_rst_n !== er) begin
        n_bad++;
        $display("FAIL R6 R7 R11 pins at %0t: clk_en act %b exp %b, rst_n act %b exp %b",
                 $time, mod_clk_en, ec, mod_rst_n, er);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    n_vec++;
    if (bus_rdata !== m_rdata) begin
      n_bad++;
      $display("FAIL %s read 0x%03h: act 0x%08h exp 0x%08h", tag, a, bus_rdata, m_rdata);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 12; k++) begin
      rd(A_STAT, "R5");
      if (bus_rdata[0] == 1'b0) break;
    end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < N; i++) begin
      rd(A_STS + 12'(4 * i), tag);
      rd(A_CTL + 12'(4 * i), tag);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    read_all("R1");
    rd(A_STAT, "R1");
    // R4 requests without start
    wr(A_CTL + 12'h0, 32'h3);
    wr(A_CTL + 12'h4, 32'h1);
    wr(A_CTL + 12'h14, 32'h3);
    repeat (3) @(negedge clk);
    rd(A_STS + 12'h0, "R4");
    rd(A_CTL + 12'h4, "R2");
    // R5 first batch, polling busy every cycle
    wr(A_CMD, 32'h1);
    wait_idle();
    read_all("R5");
    // R7 R8: mod5 already on, go and write during busy
    wr(A_CTL + 12'h0, 32'h0);
    wr(A_CTL + 12'h4, 32'h3);
    wr(A_CTL + 12'h8, 32'h1);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h1);
    wr(A_CTL + 12'hC, 32'h3);
    wait_idle();
    read_all("R8");
    rd(A_STS + 12'hC, "R8");
    // R2 unused code ignored
    wr(A_CTL + 12'h8, 32'h2);
    rd(A_CTL + 12'h8, "R2");
    // R3 flag bit
    wr(A_CTL + 12'h10, 32'hFFFF_FDFC);
    rd(A_CTL + 12'h10, "R3");
    wr(A_CTL + 12'h10, 32'h0000_0200);
    rd(A_CTL + 12'h10, "R3");
    rd(A_STS + 12'h10, "R3");
    // R9 out-of-range slots
    wr(A_CTL + 12'h20, 32'h3);
    wr(A_CTL + 12'hFC, 32'h203);
    rd(A_CTL + 12'h20, "R9");
    rd(A_CTL + 12'hFC, "R9");
    rd(A_STS + 12'h24, "R9");
    // R10 command without bit 0
    wr(A_CMD, 32'hFFFF_FFFE);
    rd(A_STAT, "R10");
    rd(A_STAT, "R10");
    // batch with the earlier pending requests (mod3 0->3)
    wr(A_CMD, 32'h1);
    wait_idle();
    // R6: on->sync reset and sync reset->off
    wr(A_CTL + 12'h4, 32'h1);
    wr(A_CTL + 12'h8, 32'h0);
    wr(A_CTL + 12'hC, 32'h0);
    wr(A_CMD, 32'h1);
    wait_idle();
    read_all("R6");
    // R5 empty batch still runs four cycles
    wr(A_CMD, 32'h1);
    wait_idle();
    rd(A_STAT, "R5");
    // R1 reset again mid-state
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    read_all("R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R5 watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule